// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is a synthesizable, device-side model of asynchronous DRAM control logic. It is meant to stand in for a memory part when a controller is being verified. A fast sampling clock captures the active-low row strobe, column strobe and write enable. The block compares each sample with the one before it to find strobe edges, and it classifies the cycle from the order of those edges. A cycle can be a normal access (read, early write, read-modify-write, or page-mode column accesses under one row), a RAS-only refresh, a CAS-before-RAS refresh, or a test-mode entry. Every cycle type acts on a small storage array whose size is a parameter.

Test-mode entry is a CAS-before-RAS cycle with write enable low. Once entered, test mode stays latched until either kind of refresh cycle clears it. While test mode is on, three address bits are ignored: the row MSB, the column MSB and the column LSB. One access therefore covers a group of eight cells. A write stores the input bit in all eight cells. A read returns 1 when the eight cells agree and 0 when they do not.

Top module: `dram_cycle_model`

## Requirements
- R1: After reset the output enable and the data output are 0, test mode is off, and every cell reads 0.
- R2: A row strobe falling edge with the column strobe high latches the row address. A later column strobe falling edge latches the column. The cell index is {row, column}, and a bit written there is read back unchanged.
- R3: In an early write, write enable is low at the sample where the column strobe falls. The input bit is stored, and the output enable stays 0 for the whole cycle.
- R4: In a read, the output enable rises one sample after the column strobe falling edge is seen. It falls one sample after the column strobe rising edge is seen. While enabled, the output carries the addressed bit.
- R5: If write enable falls while the column strobe is low in a read, this is a read-modify-write. The output keeps showing the old bit, and the input bit is then stored in the same cell.
- R6: With the row strobe held low, each further column strobe falling edge starts a new access in the latched row (page mode). Each such access can be a read or a write.
- R7: If the column strobe is already low when the row strobe falls and write enable is high, the cycle is a refresh. The address is ignored, no cell changes, and test mode is cleared.
- R8: If the column strobe is low and write enable is low when the row strobe falls, test mode is entered. It stays on across later normal cycles.
- R9: A row strobe low period with no column strobe falling edge inside it is a RAS-only refresh. It changes no cell and clears test mode.
- R10: A test-mode read returns 1 when the eight cells are all equal and 0 otherwise. The eight cells are those that differ from the addressed cell only in row bit ADDR_W-1, column bit ADDR_W-1 and column bit 0.
- R11: A test-mode write, early or read-modify-write, stores the input bit into all eight cells of the group.
- R12: The row strobe must not stay low for more than RAS_MAX samples. Low periods up to that limit work normally, and a longer one is flagged as a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, forced to 0 when not enabled |
| doutEn | output | 1 | Output drive enable |

## Verification
The hardest state to reach from the ports is a test-mode read whose answer differs from what a normal read of the same address would return. Only such a read shows which mode the block is really in. To get there, the stimulus fills a group through a test-mode write, leaves test mode, and rewrites one member in normal mode. It then re-enters test mode and reads, so the all-equal flag must drop to 0. After each exit path, a normal read is chosen whose value disagrees with the group flag. Page mode and read-modify-write are driven as explicit edge sequences with the row strobe kept low.

// File: rtl/dram_cycle_pkg.sv
package dram_cycle_pkg;
  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic write;
    logic useColReg;
    logic loadOut;
  } strobe_t;

  typedef enum logic [1:0] {
    K_IDLE,
    K_ROW,
    K_PAGE,
    K_REFR
  } cyc_kind_e;
endpackage

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_cycle_pkg::*;
#(
  parameter int RAS_MAX = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  output strobe_t strb,
  output logic    testMode,
  output logic    doutEn
);
  localparam int CNT_W = $clog2(RAS_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RAS_MAX + 1);

  logic prevRas, prevCas, prevWe;
  logic rasFall, rasRise, casFall, casRise, weFall;
  logic readActive;
  cyc_kind_e kind;
  logic [CNT_W-1:0] rasCnt;

  assign rasFall = prevRas & ~rasN;
  assign rasRise = ~prevRas & rasN;
  assign casFall = prevCas & ~casN;
  assign casRise = ~prevCas & casN;
  assign weFall  = prevWe & ~weN;

  always_comb begin
    strb = '0;
    if (rasFall && casN) strb.latchRow = 1'b1;
    if (casFall && !rasN && (kind == K_ROW || kind == K_PAGE)) begin
      strb.latchCol = 1'b1;
      if (!weN) strb.write   = 1'b1;
      else      strb.loadOut = 1'b1;
    end else if (weFall && !casN && !rasN && kind == K_PAGE && readActive) begin
      strb.write     = 1'b1;
      strb.useColReg = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevRas    <= 1'b1;
      prevCas    <= 1'b1;
      prevWe     <= 1'b1;
      kind       <= K_IDLE;
      testMode   <= 1'b0;
      readActive <= 1'b0;
      doutEn     <= 1'b0;
      rasCnt     <= '0;
    end else begin
      prevRas <= rasN;
      prevCas <= casN;
      prevWe  <= weN;

      if (rasFall) begin
        if (!casN) begin
          kind     <= K_REFR;
          testMode <= !weN;
        end else begin
          kind <= K_ROW;
        end
      end else if (rasRise) begin
        if (kind == K_ROW) testMode <= 1'b0;
        kind <= K_IDLE;
      end

      if (strb.latchCol) begin
        kind       <= K_PAGE;
        readActive <= strb.loadOut;
      end

      if (casRise) begin
        doutEn     <= 1'b0;
        readActive <= 1'b0;
      end else if (strb.loadOut) begin
        doutEn <= 1'b1;
      end

      if (rasN) rasCnt <= '0;
      else if (rasCnt != CNT_SAT) rasCnt <= rasCnt + 1'b1;
    end
  end

  p_ras_max_r12: assert property (@(posedge clk) disable iff (rst)
    rasCnt <= CNT_W'(RAS_MAX));

  p_out_needs_cas_r4: assert property (@(posedge clk) disable iff (rst)
    doutEn |-> !$past(casN));

  p_entry_latch_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rasN) && !rasN && !casN && !weN) |=> testMode);

  p_early_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.write && !strb.useColReg) |=> !doutEn);

  p_one_op_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.write, strb.loadOut}));
endmodule

// File: rtl/dram_cycle_dp.sv
module dram_cycle_dp
  import dram_cycle_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              testMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              doutReg
);
  localparam int IDX_W = 2 * ADDR_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int GRP   = 8;

  logic [DEPTH-1:0]  mem;
  logic [ADDR_W-1:0] rowReg, colReg, colUse;
  logic [IDX_W-1:0]  normIdx;
  logic [IDX_W-1:0]  grpIdx [GRP];
  logic [GRP-1:0]    grpBits;
  logic              readBit;

  assign colUse  = strb.useColReg ? colReg : addr;
  assign normIdx = {rowReg, colUse};

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    localparam logic [2:0] SEL = 3'(g);
    assign grpIdx[g]  = {SEL[2], rowReg[ADDR_W-2:0], SEL[1], colUse[ADDR_W-2:1], SEL[0]};
    assign grpBits[g] = mem[grpIdx[g]];
  end

  assign readBit = testMode ? ((&grpBits) | ~(|grpBits)) : mem[normIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem     <= '0;
      rowReg  <= '0;
      colReg  <= '0;
      doutReg <= 1'b0;
    end else begin
      if (strb.latchRow) rowReg <= addr;
      if (strb.latchCol) colReg <= addr;
      if (strb.write) begin
        if (testMode) begin
          for (int g = 0; g < GRP; g++) mem[grpIdx[g]] <= din;
        end else begin
          mem[normIdx] <= din;
        end
      end
      if (strb.loadOut) doutReg <= readBit;
    end
  end

  p_rmw_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.write && strb.useColReg) |=> $stable(doutReg));

  p_load_only_read_r3: assert property (@(posedge clk) disable iff (rst)
    !strb.loadOut |=> $stable(doutReg));
endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
  import dram_cycle_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RAS_MAX = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              doutEn
);
  strobe_t strb;
  logic    testMode;
  logic    doutReg;

  dram_cycle_ctrl #(.RAS_MAX(RAS_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .rasN(rasN), .casN(casN), .weN(weN),
    .strb(strb), .testMode(testMode), .doutEn(doutEn)
  );

  dram_cycle_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .testMode(testMode),
    .addr(addr), .din(din), .doutReg(doutReg)
  );

  assign dout = doutEn & doutReg;
endmodule

// File: tb/dram_cycle_model_tb.sv
module dram_cycle_model_tb;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, doutEn;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  dram_cycle_model #(.ADDR_W(AW), .RAS_MAX(64)) u_dut (
    .clk(clk), .rst(rst), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .din(din), .dout(dout), .doutEn(doutEn)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] row;
    logic [AW-1:0] col;
    logic          val;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 4'd2,  4'd3,  1'b1},
    '{1'b1, 4'd2,  4'd4,  1'b0},
    '{1'b1, 4'd9,  4'd3,  1'b1},
    '{1'b1, 4'd15, 4'd15, 1'b1},
    '{1'b1, 4'd0,  4'd1,  1'b1},
    '{1'b0, 4'd2,  4'd3,  1'b1},
    '{1'b0, 4'd2,  4'd4,  1'b0},
    '{1'b0, 4'd9,  4'd3,  1'b1},
    '{1'b0, 4'd3,  4'd2,  1'b0},
    '{1'b0, 4'd15, 4'd15, 1'b1},
    '{1'b0, 4'd0,  4'd1,  1'b1},
    '{1'b0, 4'd0,  4'd0,  1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at a falling clock edge, then wait one full period.
  task automatic step(input logic r, input logic c, input logic w,
                      input logic [AW-1:0] a, input logic d);
    rasN = r; casN = c; weN = w; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic wrCyc(input logic [AW-1:0] row, input logic [AW-1:0] col,
                       input logic v, output logic enSeen);
    step(1, 1, 1, row, 0);
    step(0, 1, 1, row, 0);
    step(0, 0, 0, col, v);
    enSeen = doutEn;
    step(0, 1, 1, col, 0);
    enSeen = enSeen | doutEn;
    step(1, 1, 1, 0, 0);
  endtask

  task automatic rdCyc(input logic [AW-1:0] row, input logic [AW-1:0] col,
                       output logic v, output logic en, output logic enAfter);
    step(1, 1, 1, row, 0);
    step(0, 1, 1, row, 0);
    step(0, 0, 1, col, 0);
    v = dout; en = doutEn;
    step(0, 1, 1, col, 0);
    enAfter = doutEn;
    step(1, 1, 1, 0, 0);
  endtask

  task automatic cbrCyc(input logic w, input logic [AW-1:0] junk);
    step(1, 1, 1, junk, 0);
    step(1, 0, w, junk, 0);
    step(0, 0, w, junk, 0);
    step(0, 0, 1, junk, 0);
    step(1, 0, 1, junk, 0);
    step(1, 1, 1, junk, 0);
  endtask

  task automatic rasOnly(input logic [AW-1:0] row);
    step(1, 1, 1, row, 0);
    step(0, 1, 1, row, 0);
    step(0, 1, 1, row, 0);
    step(1, 1, 1, row, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nBad++;
      nVec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic v, en, enA, ew;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 doutEn", doutEn, 1'b0);
    check("R1 dout", dout, 1'b0);
    rdCyc(4'd7, 4'd9, v, en, enA);
    check("R1 cleared cell", v, 1'b0);

    // R2/R4: table of writes then reads
    foreach (VECS[i]) begin
      if (VECS[i].wr) begin
        wrCyc(VECS[i].row, VECS[i].col, VECS[i].val, ew);
        check("R3 no drive in early write", ew, 1'b0);
      end else begin
        rdCyc(VECS[i].row, VECS[i].col, v, en, enA);
        check("R2 read data", v, VECS[i].val);
        check("R4 enable while CAS low", en, 1'b1);
        check("R4 enable off after CAS rise", enA, 1'b0);
      end
    end

    // R5: read-modify-write shows old bit, then stores new
    step(1, 1, 1, 4'd2, 0);
    step(0, 1, 1, 4'd2, 0);
    step(0, 0, 1, 4'd3, 0);
    check("R5 old bit out", dout, 1'b1);
    step(0, 0, 0, 4'd3, 0);
    check("R5 old bit held", dout, 1'b1);
    check("R5 still enabled", doutEn, 1'b1);
    step(0, 1, 1, 4'd3, 0);
    step(1, 1, 1, 4'd0, 0);
    rdCyc(4'd2, 4'd3, v, en, enA);
    check("R5 new bit stored", v, 1'b0);

    // R6/R12: page mode under one long (legal) row strobe
    step(1, 1, 1, 4'd9, 0);
    step(0, 1, 1, 4'd9, 0);
    step(0, 0, 1, 4'd3, 0);
    check("R6 page read 1", dout, 1'b1);
    step(0, 1, 1, 4'd3, 0);
    step(0, 0, 0, 4'd8, 1);
    check("R6 page write quiet", doutEn, 1'b0);
    step(0, 1, 1, 4'd8, 0);
    for (int k = 0; k < 40; k++) step(0, 1, 1, 4'd0, 0);
    step(0, 0, 1, 4'd8, 0);
    check("R6 page read back", dout, 1'b1);
    check("R12 long legal RAS still works", doutEn, 1'b1);
    step(0, 1, 1, 4'd8, 0);
    step(1, 1, 1, 4'd0, 0);

    // R7: refresh ignores address, keeps data
    cbrCyc(1'b1, 4'd9);
    rdCyc(4'd9, 4'd3, v, en, enA);
    check("R7 data kept after refresh", v, 1'b1);
    rdCyc(4'd9, 4'd9, v, en, enA);
    check("R7 addressed cell untouched", v, 1'b0);

    // R8/R11: test mode entry and group write
    cbrCyc(1'b0, 4'd0);
    wrCyc(4'd5, 4'd6, 1'b1, ew);
    check("R11 test write quiet", ew, 1'b0);
    rdCyc(4'd13, 4'd15, v, en, enA);
    check("R10 group all ones", v, 1'b1);

    // R9: RAS-only exit, then normal behaviour
    rasOnly(4'd5);
    rdCyc(4'd13, 4'd15, v, en, enA);
    check("R11 far group member written", v, 1'b1);
    rdCyc(4'd5, 4'd4, v, en, enA);
    check("R11 outside group untouched", v, 1'b0);
    wrCyc(4'd5, 4'd7, 1'b0, ew);
    rdCyc(4'd5, 4'd6, v, en, enA);
    check("R9 normal read after exit", v, 1'b1);

    // R8/R10: re-enter, group now mixed
    cbrCyc(1'b0, 4'd3);
    rdCyc(4'd5, 4'd6, v, en, enA);
    check("R10 mixed group reads 0", v, 1'b0);
    rdCyc(4'd2, 4'd3, v, en, enA);
    rdCyc(4'd13, 4'd14, v, en, enA);
    check("R8 mode persists", v, 1'b0);
    wrCyc(4'd13, 4'd14, 1'b0, ew);
    rdCyc(4'd5, 4'd6, v, en, enA);
    check("R10 all zeros reads 1", v, 1'b1);

    // R7: refresh clears test mode
    cbrCyc(1'b1, 4'd6);
    wrCyc(4'd5, 4'd6, 1'b1, ew);
    rdCyc(4'd5, 4'd6, v, en, enA);
    check("R7 normal after refresh exit", v, 1'b1);
    rdCyc(4'd5, 4'd7, v, en, enA);
    check("R7 single cell write", v, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule